// File: doc/BRIEF.md
# Regulator Fault Status and Control Register

This block holds the host-visible control and status state of a supply regulator that a host configures over a two-wire serial bus. The serial front end decodes a byte write into a one-cycle `wr_stb` with `wr_data`. It also marks the sampling point of every status read with a one-cycle `rd_sample` pulse, which falls on the rising edge of the ninth bus clock of the read. The analog side sends raw condition flags: over-temperature, over-current, input undervoltage, and two output-voltage window comparisons (below 85 % of target, within 90 % of target).

The block drives the regulator's output enable, voltage code, current-limit select, over-current timer enable and tone enable. It latches faults and shuts the output off when one occurs. It keeps each fault visible in the status byte until a read has sampled it, and it raises an interrupt request while any fault or power-not-good condition is present. An all-zero status byte means the regulator is fully operational.

Top module: `supply_fault_regs`

## Requirements
- R1: After reset, all control outputs are 0, `status` is 8'h20 (only the output-disabled bit set) and `irq` is 0.
- R2: A write loads the control fields in the cycle after the strobe: `wr_data[3:0]` goes to `vsel`, bit 4 to `odt_en`, bit 6 to `ilim_high` and bit 7 to the tone request. `tone_en` is the tone request gated by `out_en`.
- R3: When `ot_raw` is high, `status[0]` is 1 and `out_en` is 0 from the next cycle on. The bit holds until a `rd_sample` cycle in which `ot_raw` is low, and stays 1 at a `rd_sample` while `ot_raw` persists.
- R4: `uv_raw` behaves like R3 on `status[7]`: it latches, disables the output, and clears only at a `rd_sample` with the condition gone.
- R5: With `odt_en` and `out_en` high, `oc_raw` held high for `OC_DET_CYC` consecutive cycles sets `status[1]` and clears `out_en` on the next edge. A low cycle of `oc_raw` restarts the count, so a shorter burst has no effect.
- R6: With `odt_en` low, `oc_raw` never sets `status[1]` and never disables the output.
- R7: `status[1]` clears at any `rd_sample`, whether or not `oc_raw` is still high.
- R8: `out_en` rises only after a write with `wr_data[5]`=1. Such a write leaves `out_en` at 0 while `status[0]` or `status[7]` is latched.
- R9: `status[4]` (power not good) is set by `vout_low` while `out_en` is 1. It is cleared by `vout_ok`, holds while neither flag is high, needs no read, and is 0 while `out_en` is 0.
- R10: `status[5]` equals the inverse of `out_en`. Bits 2, 3 and 6 read 0.
- R11: `irq` is 1 exactly when any of `status` bits 0, 1, 4 or 7 is set. The output-disabled bit alone never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle pulse: control byte written |
| wr_data | input | 8 | Written control byte |
| rd_sample | input | 1 | One-cycle pulse: status read sampling point |
| ot_raw | input | 1 | Over-temperature condition present |
| oc_raw | input | 1 | Over-current (in current limit) present |
| uv_raw | input | 1 | Input supply below minimum |
| vout_low | input | 1 | Output below 85 % of target |
| vout_ok | input | 1 | Output within 90 % of target |
| vsel | output | 4 | Output voltage code |
| odt_en | output | 1 | Over-current disable timer enabled |
| out_en | output | 1 | Regulator output enabled |
| ilim_high | output | 1 | 1 selects the higher current limit |
| tone_en | output | 1 | Tone modulation enabled |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check several rules on every cycle. A raw over-temperature or undervoltage flag turns the output off on the next edge. The output can only come on after a write, and stays off while a lock-out fault is latched. A latched flag holds between reads. With the timer disabled, over-current cannot set its flag. Power-not-good is low while the output is off and holds inside the hysteresis band. Other behaviour needs the scoreboard scenarios. These cover the exact trip cycle of the over-current count against a burst one cycle too short, the difference between read clearing of a persisting condition and read clearing of over-current, the field mapping of a write, the gating of the tone, and an interrupt that stays quiet when only the output-disabled bit is set.

// File: rtl/supply_regs_pkg.sv
package supply_regs_pkg;
  localparam int REG_W  = 8;
  localparam int VSEL_W = 4;
  // control byte field positions
  localparam int C_ODT  = 4;
  localparam int C_EN   = 5;
  localparam int C_ILIM = 6;
  localparam int C_TONE = 7;
  // status byte field positions
  localparam int S_OT   = 0;
  localparam int S_OC   = 1;
  localparam int S_PNG  = 4;
  localparam int S_DIS  = 5;
  localparam int S_UV   = 7;
endpackage

// File: rtl/sfr_fault_latch.sv
module sfr_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_sample,
  input  logic keep_i,
  output logic lat_o
);
  always_ff @(posedge clk) begin
    if (rst)                      lat_o <= 1'b0;
    else if (set_i)               lat_o <= 1'b1;
    else if (rd_sample && !keep_i) lat_o <= 1'b0;
  end

  AST_LATCH_SET: assert property (@(posedge clk) disable iff (rst)
    set_i |=> lat_o); // R3
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lat_o && !rd_sample) |=> lat_o); // R4
endmodule

// File: rtl/sfr_oc_timer.sv
module sfr_oc_timer #(
  parameter int OC_DET_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_raw,
  input  logic timer_en,
  input  logic out_en,
  output logic trip_o
);
  localparam int CW = (OC_DET_CYC > 2) ? $clog2(OC_DET_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(OC_DET_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !oc_raw || !timer_en) cnt_q <= '0;
    else if (cnt_q != LAST)          cnt_q <= cnt_q + 1'b1;
  end

  assign trip_o = oc_raw && timer_en && out_en && (cnt_q == LAST);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    !oc_raw |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/sfr_pgood_mon.sv
module sfr_pgood_mon (
  input  logic clk,
  input  logic rst,
  input  logic out_en,
  input  logic vout_low,
  input  logic vout_ok,
  output logic png_o
);
  always_ff @(posedge clk) begin
    if (rst || !out_en) png_o <= 1'b0;
    else if (vout_low)  png_o <= 1'b1;
    else if (vout_ok)   png_o <= 1'b0;
  end

  AST_PNG_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !png_o); // R9
  AST_PNG_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_en && !vout_low && !vout_ok) |=> $stable(png_o)); // R9
endmodule

// File: rtl/supply_fault_regs.sv
module supply_fault_regs
  import supply_regs_pkg::*;
#(
  parameter int OC_DET_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sample,
  input  logic              ot_raw,
  input  logic              oc_raw,
  input  logic              uv_raw,
  input  logic              vout_low,
  input  logic              vout_ok,
  output logic [VSEL_W-1:0] vsel,
  output logic              odt_en,
  output logic              out_en,
  output logic              ilim_high,
  output logic              tone_en,
  output logic [REG_W-1:0]  status,
  output logic              irq
);
  logic tone_q, en_q;
  logic ot_lat, uv_lat, oc_lat, oc_trip, png;
  logic hard_fault, lockout;

  assign hard_fault = ot_raw || uv_raw || oc_trip;
  assign lockout    = ot_lat || uv_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      vsel      <= '0;
      odt_en    <= 1'b0;
      ilim_high <= 1'b0;
      tone_q    <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      if (wr_stb) begin
        vsel      <= wr_data[VSEL_W-1:0];
        odt_en    <= wr_data[C_ODT];
        ilim_high <= wr_data[C_ILIM];
        tone_q    <= wr_data[C_TONE];
      end
      if (hard_fault)  en_q <= 1'b0;
      else if (wr_stb) en_q <= wr_data[C_EN] && !lockout;
    end
  end

  sfr_fault_latch u_ot (.clk(clk), .rst(rst), .set_i(ot_raw),  .rd_sample(rd_sample),
                        .keep_i(ot_raw), .lat_o(ot_lat));
  sfr_fault_latch u_uv (.clk(clk), .rst(rst), .set_i(uv_raw),  .rd_sample(rd_sample),
                        .keep_i(uv_raw), .lat_o(uv_lat));
  sfr_fault_latch u_oc (.clk(clk), .rst(rst), .set_i(oc_trip), .rd_sample(rd_sample),
                        .keep_i(1'b0),   .lat_o(oc_lat));

  sfr_oc_timer #(.OC_DET_CYC(OC_DET_CYC)) u_tmr (
    .clk(clk), .rst(rst), .oc_raw(oc_raw), .timer_en(odt_en),
    .out_en(en_q), .trip_o(oc_trip));

  sfr_pgood_mon u_pg (.clk(clk), .rst(rst), .out_en(en_q), .vout_low(vout_low),
                      .vout_ok(vout_ok), .png_o(png));

  assign out_en  = en_q;
  assign tone_en = tone_q && en_q;

  always_comb begin
    status        = '0;
    status[S_OT]  = ot_lat;
    status[S_OC]  = oc_lat;
    status[S_PNG] = png;
    status[S_DIS] = !en_q;
    status[S_UV]  = uv_lat;
  end

  assign irq = ot_lat || oc_lat || uv_lat || png;

  AST_FAULT_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    (ot_raw || uv_raw) |=> !out_en); // R3
  AST_EN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en) |-> $past(wr_stb)); // R8
  AST_LOCKOUT_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (lockout && !out_en) |=> !out_en); // R8
  AST_TIMER_OFF_NO_OC: assert property (@(posedge clk) disable iff (rst)
    (!odt_en && !oc_lat) |=> !oc_lat); // R6
endmodule

// File: tb/supply_fault_regs_bench.sv
module supply_fault_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sample = 1'b0;
  logic       ot_raw = 1'b0, oc_raw = 1'b0, uv_raw = 1'b0;
  logic       vout_low = 1'b0, vout_ok = 1'b1;
  logic [3:0] vsel;
  logic       odt_en, out_en, ilim_high, tone_en, irq;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic [7:0] ctl;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  supply_fault_regs #(.OC_DET_CYC(4)) u_supply_fault_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .rd_sample(rd_sample),
    .ot_raw(ot_raw), .oc_raw(oc_raw), .uv_raw(uv_raw), .vout_low(vout_low),
    .vout_ok(vout_ok), .vsel(vsel), .odt_en(odt_en), .out_en(out_en),
    .ilim_high(ilim_high), .tone_en(tone_en), .status(status), .irq(irq));

  // monitor: ctl is packed as {tone_en, ilim_high, out_en, odt_en, vsel}
  always @(negedge clk) begin
    exp_t e;
    logic [7:0] act_ctl;
    logic       exp_irq;
    if (q.size() > 0) begin
      e = q.pop_front();
      act_ctl = {tone_en, ilim_high, out_en, odt_en, vsel};
      exp_irq = |(e.st & 8'h93); // R11
      checks++;
      if (status !== e.st || act_ctl !== e.ctl || irq !== exp_irq) begin
        errors++;
        $display("FAIL %s: status=%h ctl=%h irq=%b expected status=%h ctl=%h irq=%b",
                 e.tag, status, act_ctl, irq, e.st, e.ctl, exp_irq);
      end
    end
  end

  task automatic tick(input string tag, input logic [7:0] st, input logic [7:0] ctl);
    @(posedge clk);
    #1;
    q.push_back('{tag, st, ctl});
  endtask

  task automatic wr(input logic [7:0] d, input string tag,
                    input logic [7:0] st, input logic [7:0] ctl);
    wr_stb = 1'b1; wr_data = d;
    tick(tag, st, ctl);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] st, input logic [7:0] ctl);
    rd_sample = 1'b1;
    tick(tag, st, ctl);
    rd_sample = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    tick("R1 reset state", 8'h20, 8'h00);

    wr(8'h35, "R2 field load", 8'h00, 8'h35);
    wr(8'hF5, "R2 tone and ilim", 8'h00, 8'hF5);

    vout_low = 1'b1; vout_ok = 1'b0;
    tick("R9 png set", 8'h10, 8'hF5);
    vout_low = 1'b0;
    tick("R9 png holds in band", 8'h10, 8'hF5);
    vout_ok = 1'b1;
    tick("R9 png clears without read", 8'h00, 8'hF5);

    oc_raw = 1'b1;
    for (int i = 0; i < 3; i++) tick("R5 short burst", 8'h00, 8'hF5);
    oc_raw = 1'b0;
    tick("R5 count restart", 8'h00, 8'hF5);
    oc_raw = 1'b1;
    for (int i = 0; i < 3; i++) tick("R5 before trip", 8'h00, 8'hF5);
    tick("R5 trip", 8'h22, 8'h55);
    rd("R7 oc clears while present", 8'h20, 8'h55);
    oc_raw = 1'b0;
    tick("R10 disabled only, no irq", 8'h20, 8'h55);
    wr(8'hF5, "R8 rewrite enables", 8'h00, 8'hF5);

    wr(8'hE5, "R2 timer off", 8'h00, 8'hE5);
    oc_raw = 1'b1;
    for (int i = 0; i < 6; i++) tick("R6 no oc without timer", 8'h00, 8'hE5);
    oc_raw = 1'b0;

    ot_raw = 1'b1;
    tick("R3 ot latch", 8'h21, 8'h45);
    rd("R3 ot persists at read", 8'h21, 8'h45);
    ot_raw = 1'b0;
    tick("R3 ot sticky", 8'h21, 8'h45);
    wr(8'hE5, "R8 enable ignored while latched", 8'h21, 8'h45);
    rd("R3 ot clears at read", 8'h20, 8'h45);
    wr(8'hE5, "R8 re-enable", 8'h00, 8'hE5);

    uv_raw = 1'b1;
    tick("R4 uv latch", 8'hA0, 8'h45);
    uv_raw = 1'b0;
    tick("R4 uv sticky", 8'hA0, 8'h45);
    rd("R4 uv clears at read", 8'h20, 8'h45);
    wr(8'hE5, "R8 re-enable after uv", 8'h00, 8'hE5);

    wr(8'h00, "R10 host disable", 8'h20, 8'h00);
    vout_low = 1'b1; vout_ok = 1'b0;
    tick("R9 no png while off", 8'h20, 8'h00);
    vout_low = 1'b0; vout_ok = 1'b1;
    wr(8'h80, "R2 tone gated by enable", 8'h20, 8'h00);

    repeat (2) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule